// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This block turns three lockstep framebuffer plane streams into one 24-bit colour pixel per cycle. Each pixel position carries an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word picks the source. One code value selects the direct-colour word. Every other value sends the index through a 256-entry colour palette. The memory controller fetches all three planes with the same fixed line stride of 1024 pixels, so one pixel position lines up across the planes. The largest raster is 1024 x 768. The block only sees the resulting aligned streams.

The planes are consumed together. No plane is taken until all three offer a pixel. Start-of-line and end-of-frame flags ride with the index stream and leave with the pixel they came in with. The palette has a synchronous read of one cycle. The direct path is registered in the same stage, so pixels leave in the order they arrived. A static configuration input packs the output as RGB or BGR. The palette write port exists only so a host can load colours; the block does not sequence palette programming.

Top module: `mixsrc_pixel_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o` is low, and with no plane valid, no ready is high.
- R2: The three plane readies are always equal, and they are high only in a cycle where all three plane valids are high. A pixel is taken only on such a cycle.
- R3: When bits 31:24 of the control word equal 0x03, the pixel colour is red = direct word bits 23:16, green = bits 15:8, blue = bits 7:0.
- R4: For any other control code, including 0x00, 0x02 and 0x83, the pixel colour is the palette entry addressed by the 8-bit index. Palette data is written with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: A pixel taken at a clock edge is presented on the output in the following cycle if `out_ready_i` is high.
- R6: `out_valid_o` is low in every cycle where `out_ready_i` is low. Each taken pixel leaves exactly once, in arrival order, and a stalled pixel keeps its value.
- R7: With `pack_bgr_i` = 0, `out_pix_o` carries red in bits 23:16, green in 15:8 and blue in 7:0. With `pack_bgr_i` = 1, blue is in 23:16, green in 15:8 and red in 7:0.
- R8: `px_sol_i` and `px_eof_i` sampled with a pixel appear on `out_sol_o` and `out_eof_o` alongside that same pixel.
- R9: A palette write takes effect for pixels taken after the write edge. A pixel taken on the same edge that writes its entry receives the old colour.
- R10: Bits 31:24 of the direct-colour word never affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pack_bgr_i | input | 1 | Static output order: 0 RGB, 1 BGR |
| idx_valid_i | input | 1 | Index plane valid |
| idx_ready_o | output | 1 | Index plane ready |
| idx_data_i | input | IDX_W | 8-bit palette index |
| px_sol_i | input | 1 | Start of line, qualified with the index plane |
| px_eof_i | input | 1 | End of frame, qualified with the index plane |
| dir_valid_i | input | 1 | Direct-colour plane valid |
| dir_ready_o | output | 1 | Direct-colour plane ready |
| dir_data_i | input | WORD_W | Direct-colour word |
| ctl_valid_i | input | 1 | Control plane valid |
| ctl_ready_o | output | 1 | Control plane ready |
| ctl_data_i | input | WORD_W | Control word; top byte is the source code |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | IDX_W | Palette write address |
| pal_wdata_i | input | 24 | Palette colour, R in 23:16 |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | 24 | Packed output colour |
| out_sol_o | output | 1 | Start of line for the output pixel |
| out_eof_o | output | 1 | End of frame for the output pixel |

## Verification
The assertions check the handshake rules on every cycle. The three readies must move together, and no ready may appear without all three valids. Output valid must drop whenever ready is low, and a stalled pixel must hold its value. A pending-pixel tracker in the checker flags lost or duplicated pixels. The colour itself can only be shown by the bench's scenarios. These cover the source decode for each code value, the ignored top byte of the direct word, RGB versus BGR packing, and the sideband flags. They also cover the order of a palette write against a read of the same entry on one edge. All of these are compared against a reference palette and queue kept in the bench.

// File: rtl/mixsrc_pkg.sv
package mixsrc_pkg;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/mixsrc_join.sv
module mixsrc_join #(
  parameter int N_PLANES = 3
) (
  input  logic [N_PLANES-1:0] valid_i,
  input  logic                stage_free_i,
  output logic [N_PLANES-1:0] ready_o,
  output logic                take_o
);
  logic all_v;
  assign all_v  = &valid_i;
  assign take_o = all_v & stage_free_i;

  for (genvar p = 0; p < N_PLANES; p++) begin : g_rdy
    assign ready_o[p] = take_o;
  end
endmodule

// File: rtl/mixsrc_palette.sv
module mixsrc_palette #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // read returns the pre-write contents on an address collision
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/mixsrc_pack.sv
module mixsrc_pack
  import mixsrc_pkg::*;
(
  input  rgb_t             rgb_i,
  input  logic             bgr_i,
  output logic [RGB_W-1:0] pix_o
);
  always_comb begin
    if (bgr_i) pix_o = {rgb_i.b, rgb_i.g, rgb_i.r};
    else       pix_o = {rgb_i.r, rgb_i.g, rgb_i.b};
  end
endmodule

// File: rtl/mixsrc_pixel_sel.sv
module mixsrc_pixel_sel
  import mixsrc_pkg::*;
#(
  parameter int          IDX_W    = 8,
  parameter int          WORD_W   = 32,
  parameter logic [7:0]  SEL_CODE = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pack_bgr_i,
  input  logic              idx_valid_i,
  output logic              idx_ready_o,
  input  logic [IDX_W-1:0]  idx_data_i,
  input  logic              px_sol_i,
  input  logic              px_eof_i,
  input  logic              dir_valid_i,
  output logic              dir_ready_o,
  input  logic [WORD_W-1:0] dir_data_i,
  input  logic              ctl_valid_i,
  output logic              ctl_ready_o,
  input  logic [WORD_W-1:0] ctl_data_i,
  input  logic              pal_we_i,
  input  logic [IDX_W-1:0]  pal_addr_i,
  input  logic [RGB_W-1:0]  pal_wdata_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [RGB_W-1:0]  out_pix_o,
  output logic              out_sol_o,
  output logic              out_eof_o
);
  localparam int N_PLANES = 3;
  localparam int CODE_W   = 8;

  logic [N_PLANES-1:0] plane_v, plane_r;
  logic                take, stage_free;
  logic                vld_q, sel_dir_q, sol_q, eof_q;
  rgb_t                dir_q, pal_rd, src_rgb;
  logic                sel_dir_d;

  assign plane_v    = {ctl_valid_i, dir_valid_i, idx_valid_i};
  assign stage_free = ~vld_q | out_ready_i;

  mixsrc_join #(.N_PLANES(N_PLANES)) u_join (
    .valid_i      (plane_v),
    .stage_free_i (stage_free),
    .ready_o      (plane_r),
    .take_o       (take)
  );

  assign idx_ready_o = plane_r[0];
  assign dir_ready_o = plane_r[1];
  assign ctl_ready_o = plane_r[2];

  assign sel_dir_d = (ctl_data_i[WORD_W-1 -: CODE_W] == SEL_CODE);

  mixsrc_palette #(.IDX_W(IDX_W), .DATA_W(RGB_W)) u_pal (
    .clk_i   (clk_i),
    .we_i    (pal_we_i),
    .waddr_i (pal_addr_i),
    .wdata_i (pal_wdata_i),
    .re_i    (take),
    .raddr_i (idx_data_i),
    .rdata_o (pal_rd)
  );

  // direct path registered alongside the palette read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= 1'b0;
      sel_dir_q <= 1'b0;
      sol_q     <= 1'b0;
      eof_q     <= 1'b0;
      dir_q     <= '0;
    end else if (take) begin
      vld_q     <= 1'b1;
      sel_dir_q <= sel_dir_d;
      sol_q     <= px_sol_i;
      eof_q     <= px_eof_i;
      dir_q     <= dir_data_i[RGB_W-1:0];
    end else if (out_ready_i) begin
      vld_q     <= 1'b0;
    end
  end

  assign src_rgb = sel_dir_q ? dir_q : pal_rd;

  mixsrc_pack u_pack (
    .rgb_i (src_rgb),
    .bgr_i (pack_bgr_i),
    .pix_o (out_pix_o)
  );

  assign out_valid_o = vld_q & out_ready_i;
  assign out_sol_o   = sol_q;
  assign out_eof_o   = eof_q;
endmodule

// File: rtl/mixsrc_pixel_sel_chk.sv
module mixsrc_pixel_sel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pack_bgr_i,
  input logic        idx_valid_i,
  input logic        idx_ready_o,
  input logic        dir_valid_i,
  input logic        dir_ready_o,
  input logic        ctl_valid_i,
  input logic        ctl_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [23:0] out_pix_o
);
  logic take, pend_q;
  assign take = idx_valid_i & idx_ready_o;

  // reference count of pixels taken but not yet delivered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (take)        pend_q <= 1'b1;
    else if (out_valid_o) pend_q <= 1'b0;
  end

  assert_ready_lockstep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_ready_o == dir_ready_o) && (dir_ready_o == ctl_ready_o));

  assert_ready_needs_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_ready_o |-> (idx_valid_i && dir_valid_i && ctl_valid_i));

  assert_valid_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_i |-> !out_valid_o);

  assert_no_dup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> pend_q);

  assert_delivery_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && out_ready_i) |-> out_valid_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !out_ready_i) |=> ($stable(out_pix_o) || !$stable(pack_bgr_i)));
endmodule

bind mixsrc_pixel_sel mixsrc_pixel_sel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pack_bgr_i  (pack_bgr_i),
  .idx_valid_i (idx_valid_i),
  .idx_ready_o (idx_ready_o),
  .dir_valid_i (dir_valid_i),
  .dir_ready_o (dir_ready_o),
  .ctl_valid_i (ctl_valid_i),
  .ctl_ready_o (ctl_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_pix_o   (out_pix_o)
);

// File: tb/mixsrc_pixel_sel_tb.sv
`timescale 1ns/1ps
module mixsrc_pixel_sel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pack_bgr_i = 1'b0;
  logic        idx_valid_i = 1'b0, dir_valid_i = 1'b0, ctl_valid_i = 1'b0;
  logic        idx_ready_o, dir_ready_o, ctl_ready_o;
  logic [7:0]  idx_data_i = '0;
  logic        px_sol_i = 1'b0, px_eof_i = 1'b0;
  logic [31:0] dir_data_i = '0, ctl_data_i = '0;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_addr_i = '0;
  logic [23:0] pal_wdata_i = '0;
  logic        out_valid_o, out_ready_i = 1'b0;
  logic [23:0] out_pix_o;
  logic        out_sol_o, out_eof_o;

  int checks = 0, errors = 0;
  string cur_req = "R3";
  logic [23:0] pal_m [256];
  logic [25:0] exp_q [$];

  always #4 clk_i = ~clk_i;

  mixsrc_pixel_sel u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] exp_pix(input logic [31:0] ctl, input logic [31:0] dir,
                                          input logic [7:0] idx, input logic bgr);
    logic [23:0] c;
    c = (ctl[31:24] == 8'h03) ? dir[23:0] : pal_m[idx];
    return bgr ? {c[7:0], c[15:8], c[23:16]} : c;
  endfunction

  // called 1ns after driving: predicts what the next edge does
  task automatic observe();
    logic [25:0] e;
    chk(idx_ready_o == dir_ready_o && dir_ready_o == ctl_ready_o, "R2 lockstep",
        {29'd0, idx_ready_o, dir_ready_o, ctl_ready_o}, 0);
    if (idx_ready_o)
      chk(idx_valid_i && dir_valid_i && ctl_valid_i, "R2 all valid",
          {29'd0, idx_valid_i, dir_valid_i, ctl_valid_i}, 32'h7);
    if (!out_ready_i) chk(!out_valid_o, "R6 gated valid", out_valid_o, 0);
    if (out_valid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 duplicate", out_pix_o, 0);
      else begin
        e = exp_q.pop_front();
        chk({out_sol_o, out_eof_o, out_pix_o} == e, {cur_req, " R8 pixel"},
            {6'd0, out_sol_o, out_eof_o, out_pix_o}, {6'd0, e});
      end
    end
    if (idx_valid_i && idx_ready_o)
      exp_q.push_back({px_sol_i, px_eof_i, exp_pix(ctl_data_i, dir_data_i, idx_data_i, pack_bgr_i)});
    if (pal_we_i) pal_m[pal_addr_i] = pal_wdata_i;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      idx_valid_i = 0; dir_valid_i = 0; ctl_valid_i = 0;
      out_ready_i = 1; pal_we_i = 0;
      #1 observe();
    end
  endtask

  task automatic send(input logic [31:0] ctl, input logic [31:0] dir, input logic [7:0] idx,
                      input logic sol, input logic eof,
                      input logic we, input logic [7:0] wa, input logic [23:0] wd);
    @(negedge clk_i);
    idx_valid_i = 1; dir_valid_i = 1; ctl_valid_i = 1; out_ready_i = 1;
    ctl_data_i = ctl; dir_data_i = dir; idx_data_i = idx;
    px_sol_i = sol; px_eof_i = eof;
    pal_we_i = we; pal_addr_i = wa; pal_wdata_i = wd;
    #1 observe();
    @(negedge clk_i);
    idx_valid_i = 0; dir_valid_i = 0; ctl_valid_i = 0; pal_we_i = 0;
    #1;
    chk(out_valid_o == 1'b1, "R5 latency", out_valid_o, 1);
    observe();
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      idx_valid_i = ($urandom % 4) != 0;
      dir_valid_i = ($urandom % 4) != 0;
      ctl_valid_i = ($urandom % 4) != 0;
      out_ready_i = ($urandom % 3) != 0;
      idx_data_i  = 8'($urandom);
      dir_data_i  = $urandom;
      ctl_data_i  = $urandom;
      if ($urandom % 2) ctl_data_i[31:24] = 8'h03;
      px_sol_i = ($urandom % 8) == 0;
      px_eof_i = ($urandom % 16) == 0;
      pal_we_i = ($urandom % 8) == 0;
      pal_addr_i = ($urandom % 2) ? idx_data_i : 8'($urandom);
      pal_wdata_i = 24'($urandom);
      #1 observe();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 0, "R1 valid in reset", out_valid_o, 0);
    chk(idx_ready_o == 0, "R1 ready idle", idx_ready_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    out_ready_i = 1;
    #1 chk(out_valid_o == 0, "R1 valid after reset", out_valid_o, 0);

    // load palette
    for (int a = 0; a < 256; a++) begin
      @(negedge clk_i);
      pal_we_i = 1; pal_addr_i = 8'(a);
      pal_wdata_i = {8'(a), ~8'(a), 8'(a) ^ 8'h5a};
      #1 observe();
    end
    idle(2);

    cur_req = "R3";
    send(32'h0300_0000, 32'h00a1_b2c3, 8'h10, 0, 0, 0, 0, 0);
    chk(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);
    cur_req = "R10";
    send(32'h03ff_ffff, 32'hff12_3456, 8'h20, 0, 0, 0, 0, 0);
    send(32'h0355_0000, 32'h7e65_4321, 8'h21, 0, 0, 0, 0, 0);
    cur_req = "R4";
    send(32'h0200_0000, 32'h00ff_ffff, 8'h05, 0, 0, 0, 0, 0);
    send(32'h8300_0000, 32'h00ff_ffff, 8'hff, 0, 0, 0, 0, 0);
    send(32'h0000_0000, 32'h0300_0000, 8'h00, 0, 0, 0, 0, 0);
    cur_req = "R8";
    send(32'h0100_0000, 32'h0, 8'h33, 1, 0, 0, 0, 0);
    send(32'h0300_0000, 32'h0012_3456, 8'h34, 0, 1, 0, 0, 0);
    cur_req = "R9";
    send(32'h0000_0000, 32'h0, 8'h09, 0, 0, 1, 8'h09, 24'hdead01);
    send(32'h0000_0000, 32'h0, 8'h09, 0, 0, 0, 0, 0);

    // R6: stall with ready low, then release
    cur_req = "R6";
    @(negedge clk_i);
    idx_valid_i = 1; dir_valid_i = 1; ctl_valid_i = 1; out_ready_i = 1;
    ctl_data_i = 32'h0300_0000; dir_data_i = 32'h0042_4242; idx_data_i = 8'h1;
    #1 observe();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      out_ready_i = 0;
      #1;
      chk(out_valid_o == 0, "R6 stalled valid", out_valid_o, 0);
      chk(idx_ready_o == 0, "R6 no take while full", idx_ready_o, 0);
      observe();
    end
    idle(2);

    idle(1);
    pack_bgr_i = 1;
    cur_req = "R7";
    send(32'h0300_0000, 32'h0011_2233, 8'h00, 0, 0, 0, 0, 0);
    send(32'h0000_0000, 32'h0, 8'h80, 0, 0, 0, 0, 0);

    cur_req = "R3 R4 R7 R9";
    rand_phase(3000);
    idle(3);
    pack_bgr_i = 0;
    rand_phase(3000);
    idle(3);
    chk(exp_q.size() == 0, "R6 nothing lost", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule